// File: doc/BRIEF.md
# NAND Page Hamming ECC Accumulator

This block computes a Hamming-style parity code over one NAND page while the bytes of that page move between the host and the flash device. It observes a byte stream with a valid/ready handshake. For every accepted byte it folds the byte into two kinds of parity. The column parity covers the bit positions inside each byte. The line parity covers the byte's position in the page. Once the selected page length has been consumed, the block freezes its result and raises a done flag. Software then reads the 32-bit code and compares it with the parity stored in the spare area.

A 3-bit select chooses the page length, and the width of the valid code follows that choice. Bringing the enable input low wipes the code and the done flag. Raising it again starts a fresh page at byte address zero. The ready output tells the producer whether a byte will be taken. While ready is low the block takes nothing, so a producer that must not lose bytes has to hold them until ready returns. In practice ready drops only after a complete page, or while the block is disabled.

Top module: `nand_ecc_acc`

## Requirements
- R1: During and after reset, with enable low, the code reads 0x00000000 and done reads 0.
- R2: When enable is low at a rising edge, the code becomes zero and done becomes 0 after that edge, and ready is low.
- R3: Ready is high exactly when enable is high and done is low. A byte is accepted on an edge where valid and ready are both high.
- R4: The page-length select maps 000 to 256 bytes, 001 to 512, 010 to 1024, 011 to 2048 and 100 to 4096. The codes 101, 110 and 111 select 8192 bytes.
- R5: Done rises in the cycle after the edge that accepts the last byte of the page. It then stays high while enable stays high.
- R6: With done high, strobes on the input leave the code unchanged.
- R7: Bits [5:0] hold the column parity for j = 0, 1, 2. Bit 2j is the XOR of all data bits whose bit index has bit j clear. Bit 2j+1 is the XOR of all data bits whose bit index has bit j set.
- R8: Bytes are numbered from 0 in order of acceptance. For each address bit k, bit 6+2k is the XOR of the byte parities (XOR of the 8 bits of each byte) of bytes whose address bit k is 0. Bit 7+2k is the same XOR over bytes whose address bit k is 1.
- R9: Only the low 6+2*A bits can be nonzero, where A = log2(page length). That gives 22 bits for 256 bytes and 32 bits for 8192 bytes. All higher bits read 0.
- R10: Bytes on consecutive cycles are all accepted. The code reflects each accepted byte from the cycle after its edge, including partway through a page.
- R11: If enable drops partway through a page, the next page restarts at byte address 0 with a cleared code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| page_sel | input | 3 | Page-length select (R4) |
| ecc_en | input | 1 | Enable; low clears, high computes |
| in_valid | input | 1 | Data byte valid |
| in_ready | output | 1 | Block will accept a byte |
| in_data | input | 8 | Data byte |
| ecc_result | output | 32 | Accumulated code |
| ecc_done | output | 1 | Page complete, code frozen |

## Verification
Each accepted byte appears in the code, and the final byte raises done, one cycle after the edge that accepted it. Clearing through enable also shows one cycle after the edge at which enable is sampled low. Ready is combinational, so it follows enable and done within the same cycle. The bench drives inputs on falling edges and samples on the next falling edge. Each check therefore sees exactly one rising edge's worth of update. The bench steps byte by byte, and its expected code is advanced in the same step as the byte is driven.

// File: rtl/nand_ecc_pkg.sv
package nand_ecc_pkg;
  localparam int BYTE_W     = 8;
  localparam int IDX_W      = 3;
  localparam int COL_W      = 2 * IDX_W;
  localparam int MIN_ADDR_W = 8;
  localparam int MAX_ADDR_W = 13;
  localparam int SEL_W      = 3;
  localparam int RES_W      = COL_W + 2 * MAX_ADDR_W;

  typedef logic [MAX_ADDR_W-1:0] addr_t;
  typedef logic [RES_W-1:0]      code_t;

  // Address bits used by a given page-length select; the codes above the
  // largest page collapse onto it.
  function automatic int addr_bits(input logic [SEL_W-1:0] sel);
    int n;
    n = MIN_ADDR_W + int'(sel);
    if (n > MAX_ADDR_W) n = MAX_ADDR_W;
    return n;
  endfunction

  function automatic code_t code_mask(input logic [SEL_W-1:0] sel);
    logic [RES_W:0] one_past;
    one_past = '0;
    one_past[COL_W + 2 * addr_bits(sel)] = 1'b1;
    return code_t'(one_past - 1'b1);
  endfunction

  function automatic addr_t last_addr(input logic [SEL_W-1:0] sel);
    logic [MAX_ADDR_W:0] span;
    span = '0;
    span[addr_bits(sel)] = 1'b1;
    return addr_t'(span - 1'b1);
  endfunction
endpackage

// File: rtl/nand_ecc_col.sv
module nand_ecc_col
  import nand_ecc_pkg::*;
(
  input  logic [BYTE_W-1:0] data,
  output logic [COL_W-1:0]  col,
  output logic              byte_par
);
  always_comb begin
    col = '0;
    for (int j = 0; j < IDX_W; j++) begin
      for (int i = 0; i < BYTE_W; i++) begin
        if (((i >> j) & 1) != 0) col[2*j+1] = col[2*j+1] ^ data[i];
        else                     col[2*j]   = col[2*j]   ^ data[i];
      end
    end
    byte_par = ^data;
  end
endmodule

// File: rtl/nand_ecc_ctl.sv
module nand_ecc_ctl
  import nand_ecc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             valid,
  input  logic [SEL_W-1:0] sel,
  output logic             ready,
  output logic             accept,
  output addr_t            addr,
  output logic             done
);
  addr_t cnt;

  assign ready  = en && !done;
  assign accept = valid && ready;
  assign addr   = cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      done <= 1'b0;
    end else if (!en) begin
      cnt  <= '0;
      done <= 1'b0;
    end else if (accept) begin
      if (cnt == last_addr(sel)) done <= 1'b1;
      else                       cnt  <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/nand_ecc_acc.sv
module nand_ecc_acc
  import nand_ecc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] page_sel,
  input  logic             ecc_en,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [BYTE_W-1:0] in_data,
  output logic [RES_W-1:0] ecc_result,
  output logic             ecc_done
);
  logic             accept;
  addr_t            addr;
  logic [COL_W-1:0] col_now;
  logic             bpar;
  logic [COL_W-1:0] col_acc;
  addr_t            line_lo, line_hi;
  code_t            raw;

  nand_ecc_ctl i_ctl (
    .clk(clk), .rst_n(rst_n), .en(ecc_en), .valid(in_valid), .sel(page_sel),
    .ready(in_ready), .accept(accept), .addr(addr), .done(ecc_done)
  );

  nand_ecc_col i_col (.data(in_data), .col(col_now), .byte_par(bpar));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       col_acc <= '0;
    else if (!ecc_en) col_acc <= '0;
    else if (accept)  col_acc <= col_acc ^ col_now;
  end

  for (genvar k = 0; k < MAX_ADDR_W; k++) begin : g_line
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        line_lo[k] <= 1'b0;
        line_hi[k] <= 1'b0;
      end else if (!ecc_en) begin
        line_lo[k] <= 1'b0;
        line_hi[k] <= 1'b0;
      end else if (accept) begin
        if (addr[k]) line_hi[k] <= line_hi[k] ^ bpar;
        else         line_lo[k] <= line_lo[k] ^ bpar;
      end
    end
    assign raw[COL_W+2*k]   = line_lo[k];
    assign raw[COL_W+2*k+1] = line_hi[k];
  end

  assign raw[COL_W-1:0] = col_acc;
  assign ecc_result     = raw & code_mask(page_sel);
endmodule

// File: rtl/nand_ecc_chk.sv
module nand_ecc_chk
  import nand_ecc_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic [SEL_W-1:0] page_sel,
  input logic             ecc_en,
  input logic             in_valid,
  input logic             in_ready,
  input logic [RES_W-1:0] ecc_result,
  input logic             ecc_done
);
  assert_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !ecc_en |=> (ecc_result == '0 && !ecc_done));

  assert_ready_R3: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> (ecc_en && !ecc_done));

  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ecc_done && ecc_en) |=> ecc_done);

  assert_ignore_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ecc_done && ecc_en) |=> ($stable(page_sel) -> $stable(ecc_result)));

  assert_mask_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ecc_result & ~code_mask(page_sel)) == '0);

  assert_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ecc_en && !in_valid) |=> ($stable(page_sel) -> $stable(ecc_result)));
endmodule

bind nand_ecc_acc nand_ecc_chk i_chk (
  .clk(clk), .rst_n(rst_n), .page_sel(page_sel), .ecc_en(ecc_en),
  .in_valid(in_valid), .in_ready(in_ready), .ecc_result(ecc_result),
  .ecc_done(ecc_done)
);

// File: tb/test_nand_ecc_acc.sv
module test_nand_ecc_acc;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  page_sel;
  logic        ecc_en;
  logic        in_valid;
  logic        in_ready;
  logic [7:0]  in_data;
  logic [31:0] ecc_result;
  logic        ecc_done;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  logic [2:0]  m_ce, m_co;
  logic [12:0] m_le, m_lo;

  nand_ecc_acc i_nand_ecc_acc (
    .clk(clk), .rst_n(rst_n), .page_sel(page_sel), .ecc_en(ecc_en),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .ecc_result(ecc_result), .ecc_done(ecc_done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int abits(input logic [2:0] s);
    return (s > 3'd5) ? 13 : 8 + int'(s);
  endfunction

  function automatic logic [31:0] expected(input logic [2:0] s);
    logic [31:0] v;
    logic [63:0] m;
    v = '0;
    for (int j = 0; j < 3; j++) begin
      v[2*j]   = m_ce[j];
      v[2*j+1] = m_co[j];
    end
    for (int k = 0; k < 13; k++) begin
      v[6+2*k] = m_le[k];
      v[7+2*k] = m_lo[k];
    end
    m = (64'd1 << (6 + 2*abits(s))) - 64'd1;
    return v & m[31:0];
  endfunction

  task automatic model_clear();
    m_ce = '0; m_co = '0; m_le = '0; m_lo = '0;
  endtask

  // Advance the expected code by one byte, straight from R7 and R8.
  task automatic model_add(input int a, input logic [7:0] b);
    logic p;
    p = ^b;
    for (int i = 0; i < 8; i++)
      for (int j = 0; j < 3; j++)
        if (i[j]) m_co[j] ^= b[i]; else m_ce[j] ^= b[i];
    for (int k = 0; k < 13; k++)
      if (a[k]) m_lo[k] ^= p; else m_le[k] ^= p;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One whole page. gap > 0 inserts an idle cycle after every gap-th byte.
  task automatic run_page(input logic [2:0] s, input int gap);
    int n;
    logic [31:0] frozen;
    n = 1 << abits(s);
    page_sel = s;
    ecc_en   = 1'b1;
    model_clear();
    for (int a = 0; a < n; a++) begin
      logic [7:0] b;
      b = 8'($urandom);
      if (a == n - 1) begin
        chk("R5 done low before last byte", {31'd0, ecc_done}, 32'd0);
        chk("R3 ready high mid page", {31'd0, in_ready}, 32'd1);
      end
      in_valid = 1'b1;
      in_data  = b;
      model_add(a, b);
      @(negedge clk);
      if (a == n / 2) chk("R10 partial code R7 R8", ecc_result, expected(s));
      if (gap > 0 && (a % gap) == 0) begin
        in_valid = 1'b0;
        @(negedge clk);
      end
    end
    in_valid = 1'b0;
    chk("R5 done after last byte", {31'd0, ecc_done}, 32'd1);
    chk("R8 R7 R9 R4 final code", ecc_result, expected(s));
    chk("R3 ready low when done", {31'd0, in_ready}, 32'd0);
    frozen = ecc_result;
    for (int e = 0; e < 3; e++) begin
      in_valid = 1'b1;
      in_data  = 8'hA5 + 8'(e);
      @(negedge clk);
    end
    in_valid = 1'b0;
    @(negedge clk);
    chk("R6 strobes after done ignored", ecc_result, frozen);
    chk("R5 done held", {31'd0, ecc_done}, 32'd1);
    ecc_en = 1'b0;
    @(negedge clk);
    chk("R2 clear code", ecc_result, 32'd0);
    chk("R2 clear done", {31'd0, ecc_done}, 32'd0);
    chk("R2 ready low", {31'd0, in_ready}, 32'd0);
  endtask

  initial begin
    for (int c = 0; c < WATCHDOG; c++) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; ecc_en = 1'b0; in_valid = 1'b0; in_data = '0; page_sel = '0;
    model_clear();
    repeat (3) @(negedge clk);
    chk("R1 reset code", ecc_result, 32'd0);
    chk("R1 reset done", {31'd0, ecc_done}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after reset code", ecc_result, 32'd0);

    // Restart partway through a page (R11).
    page_sel = 3'd0; ecc_en = 1'b1;
    for (int a = 0; a < 100; a++) begin
      in_valid = 1'b1; in_data = 8'($urandom);
      @(negedge clk);
    end
    in_valid = 1'b0; ecc_en = 1'b0;
    @(negedge clk);
    chk("R11 cleared mid page", ecc_result, 32'd0);
    run_page(3'd0, 0);

    // Every page length, with and without idle gaps (R4, R10).
    run_page(3'd0, 3);
    run_page(3'd1, 0);
    run_page(3'd2, 5);
    run_page(3'd3, 0);
    run_page(3'd4, 0);
    run_page(3'd5, 0);
    run_page(3'd6, 0);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule